// File: doc/BRIEF.md
# Smart Card Character Convention Codec

This block converts between an 8-bit byte and the line-level bit sequence that carries the data and parity part of a smart card character. Three plain controls select the signalling convention:
- a bit-order control picks least-significant or most-significant bit first;
- a data-invert control picks whether a logic 1 is sent high or low;
- a parity-sense control picks even or odd parity.

Setting all three to 0 gives the direct convention. Setting all three to 1 gives the inverse convention. The invert control touches only the eight data bits. The parity bit is never inverted, so in the inverse convention the odd-parity setting is what keeps parity even as seen at the card.

The transmit side accepts a byte over a valid/ready handshake. It then drives one line level per asserted bit enable: eight data bits, then the parity bit. The line returns to its high idle level on the tenth enable. Back-pressure is simple: `tx_ready` is low from the accepting edge until that tenth enable, and a byte offered meanwhile waits.

The receive side is armed by a one-cycle `rx_start` pulse, which the surrounding logic gives after it has detected the start bit. It then samples `rx_line` on each of the next nine enables and rebuilds the byte. It presents the byte with a parity-error flag. The result is held until `rx_ready` is seen together with `rx_valid`. The start bit, guard time, error signalling, retransmission and bit-rate generation all belong to the surrounding logic.

Top module: `sc_conv_codec`

## Requirements
- R1: After reset `tx_line` is 1, `tx_ready` is 1, `rx_valid` is 0 and `rx_perr` is 0.
- R2: A byte is taken on a rising clock edge with `tx_valid` and `tx_ready` both 1. `tx_ready` then stays 0 until the tenth `bit_en` after that edge. `tx_valid` and `tx_data` have no effect while `tx_ready` is 0.
- R3: With `order_msb`=0 data bit 0 is sent first and bit 7 eighth; with `order_msb`=1 bit 7 is sent first and bit 0 eighth. The parity bit is always ninth. The receiver uses the same order.
- R4: With `data_inv`=0 a data bit of 1 is sent as line level 1; with `data_inv`=1 it is sent as line level 0. The parity bit is never inverted.
- R5: The parity bit is the XOR of the eight byte bits (before inversion) XOR `parity_odd`. So 0x3B with all controls 0 sends parity 1, and 0x3F with all controls 1 sends parity 1, a high level.
- R6: Each `bit_en` seen while a frame is in progress moves `tx_line` to the next level, on that clock edge. The line holds between enables. The tenth enable drives it back to 1.
- R7: The three controls are captured when a byte is accepted or when `rx_start` arms the receiver. Changes to the controls during a frame have no effect on that frame.
- R8: After an accepted `rx_start`, the next nine `bit_en` edges sample `rx_line`. The byte is rebuilt with the inverse of the R3/R4 mapping. `rx_valid` goes to 1 on the ninth sampling edge.
- R9: `rx_perr` is 1 when the XOR of the rebuilt byte, the received parity level and `parity_odd` is 1. It is valid only while `rx_valid` is 1 and is 0 otherwise.
- R10: `rx_valid`, `rx_data` and `rx_perr` hold until an edge with `rx_ready` at 1. `rx_start` is ignored while a result is pending or a frame is being received. `bit_en` has no effect on the receiver when it is not armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| order_msb | input | 1 | 1: most-significant bit first |
| data_inv | input | 1 | 1: data bits sent inverted |
| parity_odd | input | 1 | 1: odd parity over the byte |
| bit_en | input | 1 | One-cycle enable per bit period |
| tx_valid | input | 1 | Byte offered for transmit |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_data | input | 8 | Byte to transmit |
| tx_line | output | 1 | Line level out, idles at 1 |
| rx_start | input | 1 | Arms the receiver for one frame |
| rx_line | input | 1 | Sampled line level in |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Parity error for the received byte |

## Verification
The bench sends the two initial characters: 0x3B in direct convention and 0x3F in inverse convention. A design that inverted the parity bit along with the data, or that ignored the parity sense, sends a low parity level and fails there. Mixed control settings separate the three controls, so a design that tied order to inversion shows a wrong level sequence. The bench also flips the controls in mid-frame and offers a second byte while the transmitter is busy; a design that did not capture its settings, or that took a byte while busy, corrupts the remaining bits. On receive, the bench corrupts the parity bit, holds back `rx_ready`, and sends a full stray frame while a result is pending. A design that lost or overwrote its held result under back-pressure fails these checks.

// File: rtl/sc_conv_pkg.sv
package sc_conv_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FRAME_W = BYTE_W + 1;

  typedef struct packed {
    logic msb_first;
    logic inv;
    logic odd;
  } conv_cfg_t;
endpackage

// File: rtl/sc_bit_order.sv
module sc_bit_order #(
  parameter int unsigned W = 8
) (
  input  logic         rev,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] flip;

  for (genvar i = 0; i < W; i++) begin : g_flip
    assign flip[i] = din[W-1-i];
  end

  assign dout = rev ? flip : din;
endmodule

// File: rtl/sc_tx_ser.sv
module sc_tx_ser
  import sc_conv_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  conv_cfg_t    cfg,
  input  logic         bit_en,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  output logic         tx_line
);
  localparam int unsigned FW    = W + 1;
  localparam int unsigned CNT_W = $clog2(FW + 1);

  logic             busy;
  logic [CNT_W-1:0] idx;
  logic [FW-1:0]    frame;
  logic [W-1:0]     ordered;

  sc_bit_order #(.W(W)) u_order (
    .rev  (cfg.msb_first),
    .din  (tx_data),
    .dout (ordered)
  );

  assign tx_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      frame   <= '0;
      tx_line <= 1'b1;
    end else if (!busy) begin
      if (tx_valid) begin
        busy  <= 1'b1;
        idx   <= '0;
        frame <= {(^tx_data) ^ cfg.odd, ordered ^ {W{cfg.inv}}};
      end
    end else if (bit_en) begin
      if (idx == CNT_W'(FW)) begin
        tx_line <= 1'b1;
        busy    <= 1'b0;
        idx     <= '0;
      end else begin
        tx_line <= frame[idx];
        idx     <= idx + 1'b1;
      end
    end
  end

  assert_idle_high_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);
  assert_accept_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  assert_hold_line_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_line));
  assert_count_range_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    idx <= CNT_W'(FW));
endmodule

// File: rtl/sc_rx_des.sv
module sc_rx_des
  import sc_conv_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  conv_cfg_t    cfg,
  input  logic         bit_en,
  input  logic         rx_start,
  input  logic         rx_line,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic [W-1:0] rx_data,
  output logic         rx_perr
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam int unsigned IW    = (W > 1) ? $clog2(W) : 1;

  logic             rcv;
  logic [CNT_W-1:0] idx;
  conv_cfg_t        cfg_q;
  logic [W-1:0]     levels;
  logic [W-1:0]     dec;

  sc_bit_order #(.W(W)) u_order (
    .rev  (cfg_q.msb_first),
    .din  (levels ^ {W{cfg_q.inv}}),
    .dout (dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv      <= 1'b0;
      idx      <= '0;
      cfg_q    <= '0;
      levels   <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_perr  <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
        rx_perr  <= 1'b0;
      end
      if (!rcv) begin
        if (rx_start && !rx_valid) begin
          rcv   <= 1'b1;
          idx   <= '0;
          cfg_q <= cfg;
        end
      end else if (bit_en) begin
        if (idx == CNT_W'(W)) begin
          rcv      <= 1'b0;
          rx_valid <= 1'b1;
          rx_data  <= dec;
          rx_perr  <= (^dec) ^ rx_line ^ cfg_q.odd;
        end else begin
          levels[idx[IW-1:0]] <= rx_line;
          idx                 <= idx + 1'b1;
        end
      end
    end
  end

  assert_perr_with_valid_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    rx_perr |-> rx_valid);
  assert_hold_result_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_perr)));
  assert_no_rearm_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rcv);
  assert_count_range_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    idx <= CNT_W'(W));
endmodule

// File: rtl/sc_conv_codec.sv
module sc_conv_codec
  import sc_conv_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         order_msb,
  input  logic         data_inv,
  input  logic         parity_odd,
  input  logic         bit_en,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  output logic         tx_line,
  input  logic         rx_start,
  input  logic         rx_line,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic [W-1:0] rx_data,
  output logic         rx_perr
);
  conv_cfg_t cfg;

  assign cfg = '{msb_first: order_msb, inv: data_inv, odd: parity_odd};

  sc_tx_ser #(.W(W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .bit_en   (bit_en),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_line  (tx_line)
  );

  sc_rx_des #(.W(W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .bit_en   (bit_en),
    .rx_start (rx_start),
    .rx_line  (rx_line),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .rx_perr  (rx_perr)
  );
endmodule

// File: tb/test_sc_conv_codec.sv
module test_sc_conv_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       order_msb = 1'b0, data_inv = 1'b0, parity_odd = 1'b0;
  logic       bit_en = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic       tx_line;
  logic       rx_start = 1'b0, rx_line = 1'b1, rx_ready = 1'b0;
  logic       rx_valid, rx_perr;
  logic [7:0] rx_data;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  bit          done    = 1'b0;

  always #10 clk = ~clk;

  sc_conv_codec i_sc_conv_codec (
    .clk(clk), .rst_n(rst_n), .order_msb(order_msb), .data_inv(data_inv),
    .parity_odd(parity_odd), .bit_en(bit_en), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_line(tx_line),
    .rx_start(rx_start), .rx_line(rx_line), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_perr(rx_perr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected line levels, first sent at index 0, parity at index 8.
  function automatic logic [8:0] exp_frame(input logic [7:0] d, input logic msb,
                                           input logic inv, input logic odd);
    logic [8:0] f;
    for (int k = 0; k < 8; k++) f[k] = d[msb ? 7 - k : k] ^ inv;
    f[8] = (^d) ^ odd;
    return f;
  endfunction

  task automatic set_cfg(input logic msb, input logic inv, input logic odd);
    order_msb = msb; data_inv = inv; parity_odd = odd;
  endtask

  task automatic pulse_en();
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
  endtask

  // Transmit one byte; optionally flip controls mid-frame and poke tx_valid while busy.
  task automatic tx_frame(input string tag, input logic [7:0] d, input logic msb,
                          input logic inv, input logic odd, input bit disturb);
    logic [8:0] f;
    f = exp_frame(d, msb, inv, odd);
    @(negedge clk);
    set_cfg(msb, inv, odd);
    tx_data = d; tx_valid = 1'b1;
    check({tag, " R2 ready before accept"}, tx_ready, 1);
    @(negedge clk);
    tx_valid = 1'b0;
    check({tag, " R2 ready low after accept"}, tx_ready, 0);
    check({tag, " R6 line idle before first enable"}, tx_line, 1);
    if (disturb) set_cfg(~msb, ~inv, ~odd);  // R7: must not affect this frame
    for (int k = 0; k < 10; k++) begin
      if (disturb && k == 3) begin
        tx_data = ~d; tx_valid = 1'b1;       // R2: ignored while busy
      end
      pulse_en();
      tx_valid = 1'b0;
      check($sformatf("%s R3/R4/R5/R6 bit %0d", tag, k), tx_line, (k < 9) ? f[k] : 1'b1);
      @(negedge clk);
      check($sformatf("%s R6 hold bit %0d", tag, k), tx_line, (k < 9) ? f[k] : 1'b1);
      if (k == 8) check({tag, " R2 ready low after parity"}, tx_ready, 0);
      if (k == 9) check({tag, " R2 ready after tenth enable"}, tx_ready, 1);
    end
  endtask

  // Receive one frame; flip_par corrupts the parity level.
  task automatic rx_frame(input string tag, input logic [7:0] d, input logic msb,
                          input logic inv, input logic odd, input bit flip_par,
                          input bit disturb);
    logic [8:0] f;
    f = exp_frame(d, msb, inv, odd);
    f[8] = f[8] ^ flip_par;
    @(negedge clk);
    set_cfg(msb, inv, odd);
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    if (disturb) set_cfg(~msb, ~inv, ~odd);  // R7
    for (int k = 0; k < 9; k++) begin
      rx_line = f[k];
      pulse_en();
      if (k < 8) check($sformatf("%s R8 no valid after sample %0d", tag, k), rx_valid, 0);
    end
    rx_line = 1'b1;
    check({tag, " R8 valid"}, rx_valid, 1);
    check({tag, " R8 data"}, rx_data, d);
    check({tag, " R9 parity flag"}, rx_perr, flip_par);
    repeat (3) @(negedge clk);
    check({tag, " R10 held valid"}, rx_valid, 1);
    check({tag, " R10 held data"}, rx_data, d);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check({tag, " R10 valid dropped"}, rx_valid, 0);
    check({tag, " R9 flag cleared"}, rx_perr, 0);
  endtask

  task automatic test_reset();
    check("R1 tx_line", tx_line, 1);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 rx_perr", rx_perr, 0);
  endtask

  task automatic test_initial_chars();
    logic [8:0] f;
    f = exp_frame(8'h3B, 1'b0, 1'b0, 1'b0);
    check("R5 direct 0x3B parity is 1", f[8], 1);
    f = exp_frame(8'h3F, 1'b1, 1'b1, 1'b1);
    check("R4/R5 inverse 0x3F levels", f, 9'b1_0000_0011);
    tx_frame("direct 0x3B", 8'h3B, 1'b0, 1'b0, 1'b0, 1'b0);
    tx_frame("inverse 0x3F", 8'h3F, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic test_tx_mixed();
    tx_frame("msb only", 8'hA1, 1'b1, 1'b0, 1'b0, 1'b0);
    tx_frame("inv only", 8'h5C, 1'b0, 1'b1, 1'b0, 1'b0);
    tx_frame("odd only", 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    tx_frame("disturbed R7", 8'hC4, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic test_rx();
    rx_frame("rx direct 0x3B", 8'h3B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_frame("rx inverse 0x3F", 8'h3F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    rx_frame("rx bad parity", 8'h96, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    rx_frame("rx disturbed R7", 8'h4E, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  // R10: rx_start and enables ignored while a result is pending or unarmed.
  task automatic test_rx_ignore();
    logic [8:0] f;
    f = exp_frame(8'h71, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    set_cfg(1'b0, 1'b0, 1'b0);
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    for (int k = 0; k < 9; k++) begin
      rx_line = f[k];
      pulse_en();
    end
    @(negedge clk) rx_start = 1'b1;
    @(negedge clk) rx_start = 1'b0;
    rx_line = 1'b0;
    for (int k = 0; k < 9; k++) pulse_en();
    check("R10 pending kept valid", rx_valid, 1);
    check("R10 pending data unchanged", rx_data, 8'h71);
    check("R10 pending flag unchanged", rx_perr, 0);
    rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
    for (int k = 0; k < 9; k++) pulse_en();
    rx_line = 1'b1;
    check("R10 unarmed enables give no result", rx_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_initial_chars();
    test_tx_mixed();
    test_rx();
    test_rx_ignore();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule